// File: doc/BRIEF.md
# Fixed-Priority Interrupt Arbiter with Non-Maskable Input

This block decides which interrupt a small 8-bit core should take next. It watches an asynchronous non-maskable pin and four vectored peripheral request flags. It qualifies the peripheral flags with a global enable and one enable per source. It then presents a single request and a vector number to the core, and keeps that pair steady until the core accepts it.

Handshake pulses from the core tell the arbiter when a service routine begins and when a routine returns. From these it keeps track of which level is in service and applies the nesting rules. A peripheral routine can be preempted only by the non-maskable interrupt. A non-maskable routine cannot be preempted by anything. The block also produces two wake outputs: one for the light sleep mode and one for the deep sleep mode. Only sources configured as deep-sleep capable drive the second.

Top module: `intc_fixed_prio`

## Requirements
- R1: A falling edge on `nmi_pin_i` makes the block request the non-maskable interrupt, whatever `gen_i` is. After a two-stage synchronizer and the edge latch, `irq_o` rises on the fourth rising clock edge after the pin falls.
- R2: A `svc_start_i` pulse while vector 0 is presented does two things: `irq_o` drops after that edge, and the non-maskable latch clears. Without a new falling edge, no further non-maskable request appears.
- R3: A non-maskable request is presented even while a peripheral routine is in service.
- R4: While a non-maskable routine is in service, a new falling edge on the pin is held pending and is not presented. It is presented on the second edge after the `reti_i` that ends that routine.
- R5: No peripheral request is presented while any routine (peripheral or non-maskable) is in service.
- R6: Vector encoding: 0 is the non-maskable source, and k (1 to 4) is `flag_i[k-1]`. The non-maskable source wins over every peripheral source. Among peripherals, the lowest vector number wins.
- R7: A peripheral flag forms a request only when `gen_i` is 1 and its bit in `src_en_i` is 1.
- R8: Once `irq_o` is high, it stays high and `vec_o` stays unchanged until the core pulses `svc_start_i`, even if a higher-priority peripheral flag rises meanwhile.
- R9: A `reti_i` pulse ends only the innermost routine: the non-maskable routine if it is active, otherwise the peripheral routine.
- R10: `wake_wait_o` is high when the non-maskable latch is set or any qualified peripheral flag is set. `wake_stop_o` is high under the same conditions, but counts only sources whose bit in `STOP_MASK` is 1 (the default is sources 1 and 2); the non-maskable latch always counts.
- R11: Asserting `rst_ni` low drops `irq_o` at once and clears all in-service state. Pending flags are then re-arbitrated from idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| nmi_pin_i | input | 1 | Asynchronous non-maskable pin, triggers on a falling edge |
| flag_i | input | NUM_SRC | Sticky peripheral request flags, cleared by software |
| src_en_i | input | NUM_SRC | Per-source enable bits |
| gen_i | input | 1 | Global peripheral interrupt enable |
| svc_start_i | input | 1 | Core pulse: service of the presented vector begins |
| reti_i | input | 1 | Core pulse: return from the innermost routine |
| irq_o | output | 1 | Interrupt request to the core |
| vec_o | output | VEC_W | Vector number being presented |
| wake_wait_o | output | 1 | Wake request for light sleep |
| wake_stop_o | output | 1 | Wake request for deep sleep |

## Verification
The bench targets nesting. It raises a non-maskable edge during a non-maskable routine, which a design without the in-service gate would present at once. It unwinds a non-maskable routine that nested inside a peripheral one, and a design that popped the wrong level would re-present the peripheral vector too early. It raises a higher-priority flag while a lower vector is held, to catch a design that lets `vec_o` move before acknowledge. Other scenarios catch a design that ignores `gen_i` or the per-source enables, one that lets a non-deep-sleep source wake from deep sleep, and one whose reset leaves a stale in-service bit behind.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NUM_SRC_DEF = 4;
  localparam int SYNC_STAGES = 2;
  // vector 0 is reserved for the non-maskable source
  localparam int NMI_VEC_NUM = 0;
endpackage

// File: rtl/intc_nmi_edge.sv
module intc_nmi_edge #(
  parameter int STAGES = intc_pkg::SYNC_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic clr_i,
  output logic pend_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[STAGES-2:0], pin_i};
  end

  assign fall = prev_q & ~sync_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b1;
      pend_o <= 1'b0;
    end else begin
      prev_q <= sync_q[STAGES-1];
      if (fall)       pend_o <= 1'b1;  // new edge wins over a same-cycle clear
      else if (clr_i) pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/intc_prio_pick.sv
module intc_prio_pick #(
  parameter int N     = intc_pkg::NUM_SRC_DEF,
  parameter int VEC_W = $clog2(N + 1)
) (
  input  logic [N-1:0]     req_i,
  output logic             valid_o,
  output logic [VEC_W-1:0] vec_o
);
  always_comb begin
    vec_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) vec_o = VEC_W'(i + 1);
    end
  end
  assign valid_o = |req_i;
endmodule

// File: rtl/intc_svc_ctrl.sv
module intc_svc_ctrl #(
  parameter int VEC_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             nmi_pend_i,
  input  logic             per_valid_i,
  input  logic [VEC_W-1:0] per_vec_i,
  input  logic             svc_start_i,
  input  logic             reti_i,
  output logic             irq_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             nmi_act_o,
  output logic             per_act_o,
  output logic             nmi_clr_o
);
  localparam logic [VEC_W-1:0] NMI_V = VEC_W'(intc_pkg::NMI_VEC_NUM);

  logic nmi_ok, per_ok, ack;

  assign nmi_ok    = nmi_pend_i & ~nmi_act_o;
  assign per_ok    = per_valid_i & ~nmi_act_o & ~per_act_o;
  assign ack       = irq_o & svc_start_i;
  assign nmi_clr_o = ack & (vec_o == NMI_V);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o     <= 1'b0;
      vec_o     <= '0;
      nmi_act_o <= 1'b0;
      per_act_o <= 1'b0;
    end else begin
      if (reti_i) begin
        if (nmi_act_o) nmi_act_o <= 1'b0;
        else           per_act_o <= 1'b0;
      end
      if (irq_o) begin
        if (svc_start_i) begin
          irq_o <= 1'b0;
          if (vec_o == NMI_V) nmi_act_o <= 1'b1;
          else                per_act_o <= 1'b1;
        end
      end else begin
        irq_o <= nmi_ok | per_ok;
        vec_o <= nmi_ok ? NMI_V : per_vec_i;
      end
    end
  end
endmodule

// File: rtl/intc_fixed_prio.sv
module intc_fixed_prio #(
  parameter int                 NUM_SRC   = intc_pkg::NUM_SRC_DEF,
  parameter logic [NUM_SRC-1:0] STOP_MASK = NUM_SRC'(4'b0011),
  localparam int                VEC_W     = $clog2(NUM_SRC + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               nmi_pin_i,
  input  logic [NUM_SRC-1:0] flag_i,
  input  logic [NUM_SRC-1:0] src_en_i,
  input  logic               gen_i,
  input  logic               svc_start_i,
  input  logic               reti_i,
  output logic               irq_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic               wake_wait_o,
  output logic               wake_stop_o
);
  logic               nmi_pend, nmi_clr, nmi_act, per_act;
  logic [NUM_SRC-1:0] qual;
  logic               per_valid;
  logic [VEC_W-1:0]   per_vec;

  assign qual = flag_i & src_en_i & {NUM_SRC{gen_i}};

  intc_nmi_edge u_nmi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (nmi_pin_i),
    .clr_i  (nmi_clr),
    .pend_o (nmi_pend)
  );

  intc_prio_pick #(.N(NUM_SRC), .VEC_W(VEC_W)) u_pick (
    .req_i   (qual),
    .valid_o (per_valid),
    .vec_o   (per_vec)
  );

  intc_svc_ctrl #(.VEC_W(VEC_W)) u_svc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .nmi_pend_i  (nmi_pend),
    .per_valid_i (per_valid),
    .per_vec_i   (per_vec),
    .svc_start_i (svc_start_i),
    .reti_i      (reti_i),
    .irq_o       (irq_o),
    .vec_o       (vec_o),
    .nmi_act_o   (nmi_act),
    .per_act_o   (per_act),
    .nmi_clr_o   (nmi_clr)
  );

  assign wake_wait_o = nmi_pend | (|qual);
  assign wake_stop_o = nmi_pend | (|(qual & STOP_MASK));
endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
  parameter int VEC_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             irq_i,
  input logic [VEC_W-1:0] vec_i,
  input logic             svc_start_i,
  input logic             nmi_act_i,
  input logic             per_act_i,
  input logic             wake_wait_i,
  input logic             wake_stop_i
);
  // R2
  nmi_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i && vec_i == '0 && svc_start_i) |=> (nmi_act_i && !irq_i));
  // R4
  nmi_no_nest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i && vec_i == '0) |-> !nmi_act_i);
  // R5
  per_no_nest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i && vec_i != '0) |-> (!nmi_act_i && !per_act_i));
  // R8
  vec_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i && !svc_start_i) |=> (irq_i && $stable(vec_i)));
  // R10
  wake_subset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_stop_i |-> wake_wait_i);
endmodule

bind intc_fixed_prio intc_chk #(.VEC_W(VEC_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .irq_i       (irq_o),
  .vec_i       (vec_o),
  .svc_start_i (svc_start_i),
  .nmi_act_i   (nmi_act),
  .per_act_i   (per_act),
  .wake_wait_i (wake_wait_o),
  .wake_stop_i (wake_stop_o)
);

// File: tb/test_intc_fixed_prio.sv
module test_intc_fixed_prio;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       nmi = 1'b1;
  logic [3:0] flags = '0;
  logic [3:0] en = '0;
  logic       gen = 1'b0;
  logic       svc = 1'b0;
  logic       reti = 1'b0;
  logic       irq;
  logic [2:0] vec;
  logic       wk_wait, wk_stop;
  int         total = 0;
  int         bad = 0;

  always #5 clk = ~clk;

  intc_fixed_prio i_intc_fixed_prio (
    .clk_i(clk), .rst_ni(rst_n), .nmi_pin_i(nmi), .flag_i(flags),
    .src_en_i(en), .gen_i(gen), .svc_start_i(svc), .reti_i(reti),
    .irq_o(irq), .vec_o(vec), .wake_wait_o(wk_wait), .wake_stop_o(wk_stop)
  );

  task automatic check(input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic ack();
    svc = 1'b1; tick(); svc = 1'b0;
  endtask

  task automatic ret();
    reti = 1'b1; tick(); reti = 1'b0;
  endtask

  task automatic t_reset();
    check(irq, 0, "R11 irq after reset");
    check(wk_wait, 0, "R11 wake_wait after reset");
    check(wk_stop, 0, "R11 wake_stop after reset");
  endtask

  task automatic t_nmi();
    gen = 1'b0;
    nmi = 1'b0;
    tick(3);
    check(irq, 0, "R1 irq not yet at third edge");
    check(wk_wait, 1, "R10 nmi wakes wait");
    check(wk_stop, 1, "R10 nmi wakes stop");
    tick();
    check(irq, 1, "R1 nmi irq with gen off");
    check(vec, 0, "R6 nmi vector");
    nmi = 1'b1;
    tick(3);
    check(irq, 1, "R8 nmi held until ack");
    ack();
    check(irq, 0, "R2 irq drops after ack");
    tick(6);
    check(irq, 0, "R2 no repeat without new edge");
    nmi = 1'b0;
    tick(6);
    check(irq, 0, "R4 nmi blocked during nmi routine");
    ret();
    check(irq, 0, "R4 not yet on reti edge");
    tick();
    check(irq, 1, "R4 pending nmi after reti");
    check(vec, 0, "R4 pending nmi vector");
    ack();
    nmi = 1'b1;
    ret();
    tick(3);
  endtask

  task automatic t_priority();
    gen = 1'b1; en = 4'b1111; flags = 4'b1100;
    tick();
    check(irq, 1, "R6 periph irq");
    check(vec, 3, "R6 lowest pending vector");
    flags = 4'b1110;
    tick(2);
    check(vec, 3, "R8 vector held despite higher flag");
    ack();
    tick(3);
    check(irq, 0, "R5 no periph nesting");
    ret();
    tick();
    check(irq, 1, "R9 periph re-request after reti");
    check(vec, 2, "R6 new winner");
    flags = 4'b0000;
    ack();
    ret();
  endtask

  task automatic t_qualify();
    flags = 4'b0001; en = 4'b0001; gen = 1'b0;
    tick(3);
    check(irq, 0, "R7 gen off blocks");
    check(wk_wait, 0, "R7 gen off no wake");
    gen = 1'b1; en = 4'b0000;
    tick(3);
    check(irq, 0, "R7 source enable off blocks");
    en = 4'b0001;
    tick();
    check(irq, 1, "R7 qualified irq");
    check(vec, 1, "R7 vector 1");
    flags = 4'b0000;
    ack();
    ret();
  endtask

  task automatic t_nest();
    gen = 1'b1; en = 4'b1111; flags = 4'b1000;
    tick();
    check(vec, 4, "R6 vector 4");
    ack();
    nmi = 1'b0;
    tick(4);
    check(irq, 1, "R3 nmi preempts periph");
    check(vec, 0, "R3 nmi vector");
    ack();
    nmi = 1'b1;
    ret();
    tick(4);
    check(irq, 0, "R9 periph still active after nmi return");
    ret();
    tick();
    check(irq, 1, "R9 periph re-request after second reti");
    check(vec, 4, "R9 vector 4 again");
    flags = 4'b0000;
    ack();
    ret();
  endtask

  task automatic t_wake();
    gen = 1'b1; en = 4'b1111; flags = 4'b0100;
    #1;
    check(wk_wait, 1, "R10 src3 wakes wait");
    check(wk_stop, 0, "R10 src3 not stop capable");
    flags = 4'b0110;
    #1;
    check(wk_stop, 1, "R10 src2 stop capable");
    tick();
    check(vec, 2, "R6 src2 over src3");
    flags = 4'b0000;
    ack();
    ret();
  endtask

  task automatic t_reset_mid();
    gen = 1'b1; en = 4'b0001; flags = 4'b0001;
    tick();
    ack();
    tick(2);
    check(irq, 0, "R5 blocked before reset");
    rst_n = 1'b0;
    #1;
    check(irq, 0, "R11 irq low in reset");
    tick();
    rst_n = 1'b1;
    tick();
    check(irq, 1, "R11 in-service cleared by reset");
    check(vec, 1, "R11 vector after reset");
    flags = 4'b0000;
    ack();
    ret();
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog: actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    tick(2);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_nmi();
    t_priority();
    t_qualify();
    t_nest();
    t_wake();
    t_reset_mid();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule